// File: doc/BRIEF.md
# Voltage Code Capture and Shutdown Sequencer

This block is the digital front end of a regulator controller. It watches a 6-bit voltage-code bus driven by a load processor and an enable input. It does not trust a code until the bus has held still for a settling window. Once the code has settled, the block latches it as the reference code for the regulator's DAC. Larger code values mean lower output voltage. One code value, a parameter, means "off".

When the enable input is removed, the block moves the reference toward the off code, one step per programmable interval. It then turns the power stage off, either when the off code is reached or when a safety timeout expires. The timeout is always kept below half a second. During this wind-down the reference may only fall in voltage. A bus code is accepted then only if it asks for a lower voltage than the present reference.

After shutdown, the power stage comes back only once a new code has settled with enable present. The controller has three states:

- `ST_OFF`: power stage disabled, reference parked at the off code.
- `ST_RUN`: power stage enabled, every settled code is followed.
- `ST_RAMP`: power stage still enabled, reference winding down.

Its transitions are:

- `OFF→RUN`: enable is high and a settled code is captured.
- `RUN→RAMP`: enable is seen low.
- `RAMP→OFF`: the off code is reached or the timeout expires.

Top module: `vcode_shutdown_seq`

## Requirements
- R1: After reset the reference code is the off code (63 at defaults), and the strobe, the stage enable and the done flag are all low.
- R2: The code bus and the enable pass through two-flop synchronizers. A code is latched only after the synchronized bus has been unchanged for SETTLE_CYC = ceil(SETTLE_NS*CLK_MHZ/1000) consecutive cycles, which is 100 at the defaults. A change in any bit restarts the window.
- R3: `ref_strobe` is high for exactly one clock each time a settled bus code is latched. It is never raised by a wind-down step.
- R4: In `ST_OFF` with enable high, the first settled code is latched. `stage_enable` rises in the same cycle as the strobe, and `off_done` is cleared.
- R5: In `ST_RUN` with enable high, every settled code is latched, whether it is above or below the present reference.
- R6: When enable goes low in `ST_RUN`, the block enters `ST_RAMP`. There the reference rises by one code every STEP_CYCLES clocks toward the off code and never decreases.
- R7: In `ST_RAMP` a settled bus code is latched, with a strobe, only if its value is greater than the present reference. Any other settled code is ignored.
- R8: When the reference equals the off code in `ST_RAMP`, the next clock drops `stage_enable` and sets `off_done`.
- R9: If the off code has not been reached TIMEOUT_CYCLES clocks after entering `ST_RAMP`, the block forces the reference to the off code, drops `stage_enable` and sets `off_done`. The timeout is clamped below 500 ms at CLK_MHZ.
- R10: Enable re-asserted during `ST_RAMP` has no effect. After `off_done` is set, `off_done` stays high and `stage_enable` stays low until a fresh full settling window has elapsed with enable high and a code has been captured.
- R11: Whenever `stage_enable` is low, `ref_code` equals the off code, which commands the output stage to high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| volt_code_in | input | 6 | Asynchronous voltage-code bus |
| rail_enable | input | 1 | Asynchronous output enable request |
| ref_code | output | 6 | Latched reference code |
| ref_strobe | output | 1 | One-clock pulse when a bus code is latched |
| stage_enable | output | 1 | Power-stage enable |
| off_done | output | 1 | Shutdown complete flag |

## Verification
Suppose the settle counter or the change detector holds a wrong value. Then a strobe would appear fewer than 100 clocks after the last bus edge, or it would fail to appear at all. The bench sees this within one settling window of the offending stimulus.

Suppose the controller sits in a wrong state or its step logic is off. Then `ref_code` would move down, or move at the wrong rate, while `stage_enable` is still high during a wind-down. Or `off_done` would rise earlier or later than the expected ramp length or timeout. Either shows within one step interval, or at the end of that shutdown.

A controller that returns to `ST_RUN` too eagerly shows up as `stage_enable` rising before a full window has passed after `off_done`.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_RAMP = 2'd2
    } seq_state_t;

    // Settling window in clocks, rounded up, never below one.
    function automatic int settle_clocks(input int window_ns, input int clk_mhz);
        int c;
        c = (window_ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Largest allowed shutdown bound: 500 ms expressed in clocks.
    function automatic int shutdown_limit(input int clk_mhz);
        return 500_000 * clk_mhz;
    endfunction

endpackage

// File: rtl/vseq_sync.sv
`timescale 1ns/1ps
module vseq_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_i;
            stage2 <= stage1;
        end
    end

    assign sync_o = stage2;

endmodule

// File: rtl/vseq_settle.sv
`timescale 1ns/1ps
module vseq_settle #(
    parameter int WIDTH      = 6,
    parameter int SETTLE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] code_o,
    output logic             settled_o
);

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);
    localparam int AW = $clog2(SETTLE_CYC + 2);
    localparam logic [AW-1:0] AGE_MAX = AW'(SETTLE_CYC + 1);

    logic [WIDTH-1:0] held;
    logic [CW-1:0]    cnt;
    logic             armed;
    logic             moved;

    assign moved  = (bus_i != held);
    assign code_o = held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            cnt       <= LOAD;
            armed     <= 1'b1;
            settled_o <= 1'b0;
        end else if (restart || moved) begin
            held      <= bus_i;
            cnt       <= LOAD;
            armed     <= 1'b1;
            settled_o <= 1'b0;
        end else if (cnt != '0) begin
            cnt       <= cnt - 1'b1;
            settled_o <= 1'b0;
        end else begin
            settled_o <= armed;
            armed     <= 1'b0;
        end
    end

    // Independent age counter for the settling checks.
    logic [AW-1:0] stable_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_age <= '0;
        end else if (restart || moved) begin
            stable_age <= '0;
        end else if (stable_age != AGE_MAX) begin
            stable_age <= stable_age + 1'b1;
        end
    end

    // R2: a moving bus or a restart never yields a capture on the next clock
    a_r2_no_latch_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || moved) |=> !settled_o);

    // R2: a capture only follows a full window of stability
    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> (stable_age >= AW'(SETTLE_CYC)));

    // R3: the settle pulse lasts one clock
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |=> !settled_o);

endmodule

// File: rtl/vseq_tick.sv
`timescale 1ns/1ps
module vseq_tick #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign hit = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vcode_shutdown_seq.sv
`timescale 1ns/1ps
module vcode_shutdown_seq
    import vseq_pkg::*;
#(
    parameter int              CODE_W         = 6,
    parameter int              CLK_MHZ        = 250,
    parameter int              SETTLE_NS      = 400,
    parameter logic [CODE_W-1:0] OFF_CODE     = '1,
    parameter int              STEP_CYCLES    = 64,
    parameter int              TIMEOUT_CYCLES = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] volt_code_in,
    input  logic              rail_enable,
    output logic [CODE_W-1:0] ref_code,
    output logic              ref_strobe,
    output logic              stage_enable,
    output logic              off_done
);

    localparam int SETTLE_CYC = settle_clocks(SETTLE_NS, CLK_MHZ);
    localparam int OFF_LIMIT  = shutdown_limit(CLK_MHZ);
    localparam int TO_EFF     = (TIMEOUT_CYCLES < OFF_LIMIT) ? TIMEOUT_CYCLES : OFF_LIMIT - 1;
    localparam int AGE_W      = $clog2(TO_EFF + 2);

    logic [CODE_W-1:0] bus_s;
    logic              en_s;
    logic [CODE_W-1:0] cand_code;
    logic              settled;
    logic              restart;
    logic              step_hit;
    logic              to_hit;
    logic              at_floor;
    logic              take;
    logic              leave_ramp;

    seq_state_t state, state_nxt;

    vseq_sync #(.WIDTH(CODE_W)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .async_i(volt_code_in), .sync_o(bus_s)
    );

    vseq_sync #(.WIDTH(1)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rail_enable), .sync_o(en_s)
    );

    vseq_settle #(.WIDTH(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .restart(restart), .bus_i(bus_s),
        .code_o(cand_code), .settled_o(settled)
    );

    vseq_tick #(.LIMIT(STEP_CYCLES)) u_step_tick (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RAMP), .hit(step_hit)
    );

    vseq_tick #(.LIMIT(TO_EFF)) u_timeout_tick (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RAMP), .hit(to_hit)
    );

    assign at_floor   = (ref_code >= OFF_CODE);
    assign leave_ramp = (state == ST_RAMP) && (to_hit || at_floor);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (en_s && settled) state_nxt = ST_RUN;
            ST_RUN:  if (!en_s)           state_nxt = ST_RAMP;
            ST_RAMP: if (to_hit || at_floor) state_nxt = ST_OFF;
            default: state_nxt = ST_OFF;
        endcase
    end

    // Capture rule: follow freely while enabled, only downward in voltage otherwise
    always_comb begin
        take = 1'b0;
        if (settled) begin
            unique case (state)
                ST_OFF:  take = en_s;
                ST_RUN:  take = en_s || (cand_code > ref_code);
                ST_RAMP: take = !leave_ramp && (cand_code > ref_code);
                default: take = 1'b0;
            endcase
        end
    end

    // Fresh window whenever the sequencer parks or waits for enable
    assign restart = ((state == ST_OFF) && !en_s) || leave_ramp;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_code     <= OFF_CODE;
            ref_strobe   <= 1'b0;
            stage_enable <= 1'b0;
            off_done     <= 1'b0;
        end else begin
            ref_strobe   <= take;
            stage_enable <= (state_nxt != ST_OFF);
            if (leave_ramp) begin
                ref_code <= OFF_CODE;
                off_done <= 1'b1;
            end else if (take) begin
                ref_code <= cand_code;
                if (state == ST_OFF) off_done <= 1'b0;
            end else if ((state == ST_RAMP) && step_hit && !at_floor) begin
                ref_code <= ref_code + 1'b1;
            end
        end
    end

    // Checker-side age of the current wind-down
    logic [AGE_W-1:0] ramp_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ramp_age <= '0;
        else if (state == ST_RAMP)  ramp_age <= ramp_age + 1'b1;
        else                        ramp_age <= '0;
    end

    // R6: reference never rises in voltage while winding down
    a_r6_ramp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP) |=> (ref_code >= $past(ref_code)));

    // R7: a capture during wind-down must lower the voltage
    a_r7_capture_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RAMP) && ref_strobe && $past(state == ST_RAMP)) |-> (ref_code > $past(ref_code)));

    // R8: done and stage enable are never high together
    a_r8_done_excludes_stage: assert property (@(posedge clk) disable iff (!rst_n)
        off_done |-> !stage_enable);

    // R9: a wind-down never lasts past the timeout
    a_r9_bounded_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP) |-> (ramp_age < AGE_W'(TO_EFF)));

    // R11: disabled stage always sees the off code
    a_r11_off_ref: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_enable |-> (ref_code == OFF_CODE));

    // R3: strobe only follows a settle pulse
    a_r3_strobe_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> $past(settled));

    // R10: enable has no say while winding down
    a_r10_ramp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RAMP) && !to_hit && !at_floor) |=> (state == ST_RAMP));

endmodule

// File: tb/vcode_shutdown_seq_bench.sv
`timescale 1ns/1ps
module vcode_shutdown_seq_bench;

    localparam int CLK_MHZ  = 250;
    localparam int SET_NS   = 400;
    localparam int STEP     = 4;
    localparam int TO       = 200;
    localparam int OFF      = 63;
    localparam int S        = (SET_NS * CLK_MHZ + 999) / 1000;
    localparam int WD_LIMIT = 150_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] vcode = 6'd0;
    logic       en = 1'b0;
    logic [5:0] ref_code;
    logic       ref_strobe;
    logic       stage_enable;
    logic       off_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    vcode_shutdown_seq #(
        .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SET_NS),
        .STEP_CYCLES(STEP), .TIMEOUT_CYCLES(TO)
    ) u_vcode_shutdown_seq (
        .clk(clk), .rst_n(rst_n), .volt_code_in(vcode), .rail_enable(en),
        .ref_code(ref_code), .ref_strobe(ref_strobe),
        .stage_enable(stage_enable), .off_done(off_done)
    );

    // Expected wind-down length from a starting code, capped by the timeout
    function automatic int exp_shutdown(input int start);
        int r;
        r = (OFF - start) * STEP;
        return (r < TO) ? r : TO;
    endfunction

    function automatic bit exp_accept_in_ramp(input int code, input int cur);
        return code > cur;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step1;
        @(posedge clk);
        #1;
    endtask

    task automatic wait_strobe(input int maxc, output int lat, output bit seen);
        lat = 0;
        seen = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            step1();
            lat++;
            if (ref_strobe) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic settle_code(input int code, input string tag);
        int lat;
        bit seen;
        vcode = 6'(code);
        wait_strobe(S + 20, lat, seen);
        chk(seen, {tag, " strobe seen"}, int'(seen), 1);
        chk(int'(ref_code) == code, {tag, " latched code"}, int'(ref_code), code);
        step1();
        chk(!ref_strobe, "R3 strobe one clock", int'(ref_strobe), 0);
    endtask

    task automatic run_shutdown(input int new_code, input int code_at, input int reen_at,
                                output int lat, output bit mono, output int n_strobe,
                                output int strobe_ref, output bit pen_ok);
        int prev;
        lat = 0;
        mono = 1'b1;
        n_strobe = 0;
        strobe_ref = -1;
        pen_ok = 1'b1;
        prev = int'(ref_code);
        en = 1'b0;
        for (int i = 0; i < TO + 60; i++) begin
            step1();
            lat++;
            if (new_code >= 0 && i == code_at) vcode = 6'(new_code);
            if (reen_at >= 0 && i == reen_at) en = 1'b1;
            if (int'(ref_code) < prev) mono = 1'b0;
            prev = int'(ref_code);
            if (ref_strobe) begin
                n_strobe++;
                strobe_ref = int'(ref_code);
            end
            if (off_done) break;
            if (!stage_enable) pen_ok = 1'b0;
        end
    endtask

    task automatic recover(input int code, input string tag);
        int lat;
        bit seen;
        en = 1'b1;
        wait_strobe(S + 20, lat, seen);
        chk(seen && lat >= S, {tag, " fresh window before restart"}, lat, S);
        chk(int'(ref_code) == code && stage_enable, {tag, " restart code"}, int'(ref_code), code);
        chk(!off_done, "R4 done cleared", int'(off_done), 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        int n_str;
        int s_ref;
        bit seen;
        bit mono;
        bit pen_ok;
        int cur;
        int nxt;

        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk(int'(ref_code) == OFF, "R1 ref at off", int'(ref_code), OFF);
        chk(!ref_strobe && !stage_enable && !off_done, "R1 outputs low",
            int'({ref_strobe, stage_enable, off_done}), 0);
        rst_n = 1'b1;
        step1();

        // R4 / R2: first capture from off
        vcode = 6'd21;
        repeat (20) step1();
        chk(!stage_enable, "R4 stage off without enable", int'(stage_enable), 0);
        en = 1'b1;
        wait_strobe(S + 20, lat, seen);
        chk(seen && lat >= S + 1 && lat <= S + 6, "R2 first capture latency", lat, S + 3);
        chk(int'(ref_code) == 21, "R4 first code", int'(ref_code), 21);
        chk(stage_enable && !off_done, "R4 stage enabled with strobe",
            int'({stage_enable, off_done}), 2);
        step1();
        chk(!ref_strobe, "R3 strobe one clock", int'(ref_strobe), 0);

        // R2: codes that keep moving inside the window are never latched
        cur = 21;
        n_str = 0;
        for (int k = 0; k < 6; k++) begin
            nxt = (cur + 1 + int'($urandom % 63)) % 64;
            vcode = 6'(nxt);
            cur = nxt;
            for (int j = 0; j < S / 2; j++) begin
                step1();
                if (ref_strobe) n_str++;
            end
        end
        chk(n_str == 0, "R2 no capture while settling", n_str, 0);
        wait_strobe(S + 20, lat, seen);
        chk(seen && int'(ref_code) == cur, "R2 capture after bus holds", int'(ref_code), cur);

        // R5: random settled codes followed in either direction
        for (int k = 0; k < 6; k++) begin
            nxt = (cur + 1 + int'($urandom % 63)) % 64;
            settle_code(nxt, "R5 running capture");
            cur = nxt;
        end

        // R6 / R8 / R10: natural wind-down with enable re-asserted midway
        settle_code(40, "R5 set 40");
        run_shutdown(-1, 0, 20, lat, mono, n_str, s_ref, pen_ok);
        chk(mono, "R6 monotonic ramp", int'(mono), 1);
        chk(lat >= exp_shutdown(40) && lat <= exp_shutdown(40) + 8, "R8 ramp length",
            lat, exp_shutdown(40));
        chk(pen_ok, "R10 stage held during ramp", int'(pen_ok), 1);
        chk(n_str == 0, "R3 no strobe on steps", n_str, 0);
        chk(off_done && !stage_enable && int'(ref_code) == OFF, "R8 done at off code",
            int'(ref_code), OFF);
        // R10 / R11: parked for a full fresh window
        n_str = 0;
        for (int j = 0; j < S - 2; j++) begin
            step1();
            if (stage_enable || int'(ref_code) != OFF || !off_done) n_str++;
        end
        chk(n_str == 0, "R11 parked at off code with done", n_str, 0);
        wait_strobe(30, lat, seen);
        chk(seen && int'(ref_code) == 40 && stage_enable, "R10 restart after window",
            int'(ref_code), 40);

        // R9: timeout path from the highest voltage code
        settle_code(0, "R5 set 0");
        run_shutdown(-1, 0, -1, lat, mono, n_str, s_ref, pen_ok);
        chk(lat >= TO && lat <= TO + 8, "R9 timeout length", lat, exp_shutdown(0));
        chk(off_done && !stage_enable && int'(ref_code) == OFF, "R9 forced off",
            int'(ref_code), OFF);
        chk(mono, "R6 monotonic before timeout", int'(mono), 1);
        recover(0, "R10");

        // R7: lower-voltage code accepted during wind-down
        settle_code(10, "R5 set 10");
        run_shutdown(50, 15, -1, lat, mono, n_str, s_ref, pen_ok);
        chk(exp_accept_in_ramp(50, 10 + 30) && n_str == 1 && s_ref == 50,
            "R7 lower voltage taken", s_ref, 50);
        chk(mono && pen_ok && off_done, "R7 ramp completes", int'({mono, pen_ok, off_done}), 7);
        recover(50, "R10");

        // R7: higher-voltage code ignored during wind-down
        settle_code(20, "R5 set 20");
        run_shutdown(5, 10, -1, lat, mono, n_str, s_ref, pen_ok);
        chk(!exp_accept_in_ramp(5, 20) && n_str == 0, "R7 higher voltage ignored", n_str, 0);
        chk(mono, "R7 ref never rises in voltage", int'(mono), 1);
        chk(lat >= exp_shutdown(20) && lat <= exp_shutdown(20) + 8, "R8 ramp from 20",
            lat, exp_shutdown(20));

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule